// File: doc/BRIEF.md
# Burst Auto-Refresh Scheduler

This block keeps a low-power DDR memory refreshed by grouping refreshes. Rather than issuing one auto-refresh command per refresh interval, it lets several intervals accumulate. Once the scaled interval has elapsed, it asks the command arbiter for ownership of the memory bus. After the grant it fires a fixed number of auto-refresh commands back to back. Each command is spaced by the refresh recovery time, and no user command is slipped between them.

A build option adds a retraining step at the end of each burst. When it is set, the block raises an I/O retraining request after the last refresh has recovered. It then keeps the bus until the training logic reports completion. When the option is clear, the block drops back to idle as soon as the burst is over.

The arbiter link behaves as a valid/ready pair. `arb_req` is the valid side, and once raised it stays high until `arb_gnt` is sampled high with it. A grant seen while no request is pending is ignored. The arbiter may hold off the grant for as long as it needs, for example to let a user command that is already in flight finish. The block never withdraws a pending request. While `busy` is high, the arbiter must keep user traffic off the bus. The retraining pair follows the same rule: `retrain_req` is held until `retrain_done` is sampled high with it. A high `retrain_done` at any other time has no effect.

Top module: `burst_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `arb_req`, `ref_cmd`, `busy` and `retrain_req` are all 0.
- R2: With `ref_en` held high, `arb_req` rises LIMIT = BASE_INTERVAL × BURST_CNT clock edges after the release of reset or after the grant edge. The interval counter restarts at the grant edge, so cycles spent waiting for the grant are not counted.
- R3: Once high, `arb_req` stays high until the edge at which `arb_gnt` is sampled high, and falls after that edge. `arb_gnt` sampled while `arb_req` is low is ignored.
- R4: After a grant, `ref_cmd` pulses exactly BURST_CNT times, one cycle each. The first pulse is in the cycle right after the grant edge, and consecutive pulses are exactly TRFC cycles apart.
- R5: `busy` is high from the cycle after the grant edge until the burst ends, TRFC cycles after the last pulse. It also stays high through any retraining that follows. `arb_req` is never high while `busy` is high.
- R6: With RETRAIN_EN = 1, `retrain_req` rises in the cycle the burst ends and is held until `retrain_done` is sampled high. Both `retrain_req` and `busy` then fall after that edge.
- R7: With RETRAIN_EN = 0, the block returns to idle directly when the burst ends. `retrain_req` stays 0, and `retrain_done` has no effect.
- R8: Each edge at which `ref_en` is low leaves the interval count unchanged, so a pause of P edges delays the next request by exactly P cycles. With `ref_en` low, no new request is raised.
- R9: BURST_CNT ranges from 1 to 8. With BURST_CNT = 1, a grant produces a single `ref_cmd` pulse, and `busy` lasts TRFC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | Refresh enable; low freezes the interval count |
| arb_req | output | 1 | Bus request to the command arbiter (valid side) |
| arb_gnt | input | 1 | Grant from the arbiter (ready side) |
| ref_cmd | output | 1 | One-cycle strobe per auto-refresh command |
| busy | output | 1 | High while a burst or retraining owns the bus |
| retrain_req | output | 1 | I/O retraining request, held until done |
| retrain_done | input | 1 | Retraining complete |

## Verification
The hardest timing to reach from the ports is a refresh interval that has been both paused and deferred. In that case `ref_en` drops partway through the count, the arbiter then delays its grant, and a retraining handshake of varying length follows. The next request must still land exactly LIMIT plus the pause after the grant edge. A vector table drives all three of these delays in several combinations on one instance and predicts each request cycle from the previous grant. A second instance, built with a burst of one and no retraining, takes a stray grant and a permanently high `retrain_done` to show that both are ignored.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2,
    ST_TRAIN = 2'd3
  } rfs_state_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign expired = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && !expired) begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/rfs_burst_seq.sv
module rfs_burst_seq #(
  parameter int BURST_CNT = 8,
  parameter int TRFC      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic cmd_o,
  output logic active_o,
  output logic last_done_o
);
  localparam int GAP_W = $clog2(TRFC + 1);
  localparam int REM_W = $clog2(BURST_CNT + 1);
  localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(TRFC - 1);
  localparam logic [REM_W-1:0] REM_RELOAD = REM_W'(BURST_CNT - 1);

  logic [GAP_W-1:0] gap_q;
  logic [REM_W-1:0] rem_q;

  assign last_done_o = active_o && (gap_q == '0) && (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      cmd_o    <= 1'b0;
      gap_q    <= '0;
      rem_q    <= '0;
    end else begin
      cmd_o <= 1'b0;
      if (start) begin
        active_o <= 1'b1;
        cmd_o    <= 1'b1;
        gap_q    <= GAP_RELOAD;
        rem_q    <= REM_RELOAD;
      end else if (active_o) begin
        if (gap_q != '0) begin
          gap_q <= gap_q - GAP_W'(1);
        end else if (rem_q != '0) begin
          cmd_o <= 1'b1;
          gap_q <= GAP_RELOAD;
          rem_q <= rem_q - REM_W'(1);
        end else begin
          active_o <= 1'b0;
        end
      end
    end
  end

  // Checker-side counter: cycles since the last command, saturating.
  logic [GAP_W-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_q <= GAP_W'(TRFC);
    else if (cmd_o)                 since_q <= '0;
    else if (since_q != GAP_W'(TRFC)) since_q <= since_q + GAP_W'(1);
  end

  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o |-> (since_q >= GAP_W'(TRFC - 1))); // R4
  AST_CMD_INSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o |-> active_o); // R4
endmodule

// File: rtl/rfs_retrain_link.sv
module rfs_retrain_link #(
  parameter int ENABLE = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic done_i,
  output logic req_o,
  output logic fin_o
);
  localparam bit USE = (ENABLE != 0);

  assign fin_o = req_o && done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             req_o <= 1'b0;
    else if (kick_i && USE) req_o <= 1'b1;
    else if (fin_o)         req_o <= 1'b0;
  end

  AST_TRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !done_i) |=> req_o); // R6
endmodule

// File: rtl/burst_refresh_sched.sv
module burst_refresh_sched #(
  parameter int BASE_INTERVAL = 64,
  parameter int BURST_CNT     = 8,
  parameter int TRFC          = 8,
  parameter int RETRAIN_EN    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  output logic arb_req,
  input  logic arb_gnt,
  output logic ref_cmd,
  output logic busy,
  output logic retrain_req,
  input  logic retrain_done
);
  import rfs_pkg::*;

  localparam int  LIMIT     = BASE_INTERVAL * BURST_CNT;
  localparam bit  TRAIN_ON  = (RETRAIN_EN != 0);

  rfs_state_e state_q, state_d;
  logic       expired, grant_take, seq_active, seq_done, train_fin;

  assign arb_req    = (state_q == ST_WAIT);
  assign grant_take = arb_req && arb_gnt;
  assign busy       = seq_active || retrain_req;

  rfs_interval_timer #(.LIMIT(LIMIT)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ref_en && (state_q != ST_WAIT)),
    .clr     (grant_take),
    .expired (expired)
  );

  rfs_burst_seq #(.BURST_CNT(BURST_CNT), .TRFC(TRFC)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (grant_take),
    .cmd_o       (ref_cmd),
    .active_o    (seq_active),
    .last_done_o (seq_done)
  );

  rfs_retrain_link #(.ENABLE(RETRAIN_EN)) train_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (seq_done),
    .done_i (retrain_done),
    .req_o  (retrain_req),
    .fin_o  (train_fin)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ref_en && expired) state_d = ST_WAIT;
      ST_WAIT:  if (arb_gnt)           state_d = ST_BURST;
      ST_BURST: if (seq_done)          state_d = TRAIN_ON ? ST_TRAIN : ST_IDLE;
      ST_TRAIN: if (train_fin)         state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && !arb_gnt) |=> arb_req); // R3
  AST_NO_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !arb_req); // R5
  AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> busy); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_req && !ref_en) |=> !arb_req); // R8
  AST_TRAIN_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retrain_req) |-> $past(state_q == ST_BURST)); // R6
  AST_BURST_END_VARIANT: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (retrain_req == TRAIN_ON)); // R7
endmodule

// File: tb/burst_refresh_sched_tb_top.sv
module burst_refresh_sched_tb_top;
  localparam int A_BASE = 20, A_BURST = 4, A_TRFC = 3;
  localparam int A_LIMIT = A_BASE * A_BURST;
  localparam int B_BASE = 30, B_BURST = 1, B_TRFC = 5;
  localparam int B_LIMIT = B_BASE * B_BURST;
  localparam int NVEC = 4;
  // columns: grant delay, retrain delay, ref_en pause length
  localparam int VEC [NVEC][3] = '{'{0, 0, 0}, '{3, 2, 0}, '{7, 5, 10}, '{1, 0, 25}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_a = 1'b0, gnt_a = 1'b0, done_a = 1'b0;
  logic req_a, cmd_a, busy_a, rt_a;
  logic en_b = 1'b0, gnt_b = 1'b0, done_b = 1'b0;
  logic req_b, cmd_b, busy_b, rt_b;
  int cyc = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  burst_refresh_sched #(.BASE_INTERVAL(A_BASE), .BURST_CNT(A_BURST),
                        .TRFC(A_TRFC), .RETRAIN_EN(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(en_a), .arb_req(req_a), .arb_gnt(gnt_a),
    .ref_cmd(cmd_a), .busy(busy_a), .retrain_req(rt_a), .retrain_done(done_a));

  burst_refresh_sched #(.BASE_INTERVAL(B_BASE), .BURST_CNT(B_BURST),
                        .TRFC(B_TRFC), .RETRAIN_EN(0)) dut_nr (
    .clk(clk), .rst_n(rst_n), .ref_en(en_b), .arb_req(req_b), .arb_gnt(gnt_b),
    .ref_cmd(cmd_b), .busy(busy_b), .retrain_req(rt_b), .retrain_done(done_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int gd, input int rd, input int off, inout int base);
    int seen, g, ncmd;
    seen = -1;
    for (int i = 0; i < 400 && seen < 0; i++) begin
      @(negedge clk);
      if (off > 0 && cyc == base + 40) en_a = 1'b0;
      if (off > 0 && cyc == base + 40 + off) en_a = 1'b1;
      if (req_a) seen = cyc;
    end
    chk(seen == base + A_LIMIT + off, "R2 R8 request cycle", seen, base + A_LIMIT + off);
    for (int i = 0; i < gd; i++) begin
      @(negedge clk);
      chk(req_a == 1'b1, "R3 request held", int'(req_a), 1);
    end
    gnt_a = 1'b1;
    @(negedge clk);
    gnt_a = 1'b0;
    g = cyc;
    chk(req_a == 1'b0, "R3 request drops after grant", int'(req_a), 0);
    chk(busy_a == 1'b1, "R5 busy after grant", int'(busy_a), 1);
    chk(cmd_a == 1'b1, "R4 first command", int'(cmd_a), 1);
    ncmd = int'(cmd_a);
    for (int k = 1; k < A_BURST * A_TRFC; k++) begin
      @(negedge clk);
      chk(cmd_a == ((k % A_TRFC) == 0), "R4 command spacing", int'(cmd_a), int'((k % A_TRFC) == 0));
      chk(busy_a == 1'b1, "R5 busy during burst", int'(busy_a), 1);
      ncmd += int'(cmd_a);
    end
    chk(ncmd == A_BURST, "R4 command count", ncmd, A_BURST);
    @(negedge clk);
    chk(rt_a == 1'b1, "R6 retrain raised at burst end", int'(rt_a), 1);
    chk(cmd_a == 1'b0, "R4 no extra command", int'(cmd_a), 0);
    for (int i = 0; i < rd; i++) begin
      chk(rt_a == 1'b1 && busy_a == 1'b1, "R6 retrain held", int'(rt_a), 1);
      @(negedge clk);
    end
    done_a = 1'b1;
    @(negedge clk);
    done_a = 1'b0;
    chk(rt_a == 1'b0, "R6 retrain released", int'(rt_a), 0);
    chk(busy_a == 1'b0, "R5 busy released", int'(busy_a), 0);
    base = g;
  endtask

  initial begin
    int base, cb, seen, g, ncmd, stray;
    repeat (3) @(negedge clk);
    chk(!req_a && !cmd_a && !busy_a && !rt_a, "R1 reset outputs main", int'({req_a, cmd_a, busy_a, rt_a}), 0);
    chk(!req_b && !cmd_b && !busy_b && !rt_b, "R1 reset outputs second", int'({req_b, cmd_b, busy_b, rt_b}), 0);
    en_a = 1'b1;
    rst_n = 1'b1;
    base = cyc;
    for (int v = 0; v < NVEC; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2], base);

    // second instance: held disabled since reset, so no request yet
    @(negedge clk);
    chk(req_b == 1'b0, "R8 no request while disabled", int'(req_b), 0);
    done_b = 1'b1;  // stray done, must be ignored
    en_b = 1'b1;
    cb = cyc;
    seen = -1;
    stray = 0;
    for (int i = 0; i < 200 && seen < 0; i++) begin
      @(negedge clk);
      gnt_b = (cyc == cb + 10 || cyc == cb + 11);
      if (busy_b || cmd_b) stray++;
      if (req_b) seen = cyc;
    end
    gnt_b = 1'b0;
    chk(stray == 0, "R3 stray grant ignored", stray, 0);
    chk(seen == cb + B_LIMIT, "R2 request cycle second", seen, cb + B_LIMIT);
    gnt_b = 1'b1;
    @(negedge clk);
    gnt_b = 1'b0;
    g = cyc;
    ncmd = int'(cmd_b);
    chk(busy_b == 1'b1, "R9 busy after grant", int'(busy_b), 1);
    for (int k = 1; k < B_TRFC; k++) begin
      @(negedge clk);
      ncmd += int'(cmd_b);
      chk(busy_b == 1'b1 && rt_b == 1'b0, "R9 busy single burst", int'(busy_b), 1);
    end
    chk(ncmd == 1, "R9 single command", ncmd, 1);
    @(negedge clk);
    chk(busy_b == 1'b0, "R7 idle directly after burst", int'(busy_b), 0);
    chk(rt_b == 1'b0, "R7 no retrain request", int'(rt_b), 0);
    seen = -1;
    for (int i = 0; i < 200 && seen < 0; i++) begin
      @(negedge clk);
      if (rt_b) stray++;
      if (req_b) seen = cyc;
    end
    chk(stray == 0, "R7 retrain stays low", stray, 0);
    chk(seen == g + B_LIMIT, "R2 restart at grant", seen, g + B_LIMIT);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule